// File: doc/BRIEF.md
# Deferred Misalignment Fault Sequencer

This block sits in the control path of a small processor core. It decides when a misaligned-access fault is actually raised, and when such a fault stops the core instead. It does not fetch vectors, build stack frames or time the bus. It receives one-cycle event strobes from the core and turns them into fault requests at the right moment. It can also drop a request or turn it into a halt.

Two kinds of fault can be waiting at the same time, and each has its own holding slot. The first is a posted operand write to an odd address. That fault waits until the core next reaches an instruction boundary or starts an operand access. The second is a branch whose target has bit 0 set. That fault waits until the PC is actually loaded with the target, and it is thrown away if the branch turns out not taken.

A fault that is ready is raised as a one-cycle request. The address, return PC and instruction pointer that go with it stay held until the core acknowledges them. A fault that becomes ready while the core is already handling a critical exception does not raise a request: it sets a halt flag, and only reset clears that flag.

Top module: `addr_fault_seq`

## Requirements
- R1: After `wr_post` has loaded the write slot, `fault_req` stays low until a later cycle has `insn_bound` or `opnd_start` high. A strobe in the same cycle as the post does not count. If C is the first cycle with such a strobe, `fault_req` is high in cycle C+2, provided the sequencer is idle, not halted and `exc_ctx` is 0 in cycle C+1.
- R2: An `opnd_start` strobe releases a posted write fault just as `insn_bound` does. The request then reports `fault_addr` = the posted write address, and `fault_ret_pc` = `fault_iptr` = the `cur_pc` value of the posting cycle.
- R3: After `br_odd` has loaded the branch slot, no request is raised until a later cycle has `pc_load` high. If C is that cycle, `fault_req` is high in cycle C+2, with `fault_addr` = `fault_ret_pc` = the branch target and `fault_iptr` = the `cur_pc` value of the `br_odd` cycle.
- R4: A `br_not_taken` strobe while the branch slot is pending discards that fault. No request or halt follows, even after a later `pc_load`. When `br_not_taken` and `pc_load` come in the same cycle, the discard wins.
- R5: `exc_ctx` is encoded as 0 = normal, 1 = bus-error handling, 2 = address-error handling, 3 = reset handling. If a fault would be issued in a cycle where `exc_ctx` is not 0, `halted` rises in the next cycle and no `fault_req` is produced.
- R6: `halted` stays high until `rst`. While it is high, no `fault_req` is issued.
- R7: When both slots are ready in the same cycle, the write fault is issued first. The branch fault is issued after the write fault has been acknowledged.
- R8: `fault_req` is high for exactly one cycle. From that cycle until the cycle in which `fault_ack` is high, `fault_addr`, `fault_ret_pc` and `fault_iptr` hold their values and no other request is issued. A waiting fault is issued two cycles after the `fault_ack` cycle at the earliest.
- R9: After a synchronous reset, `fault_req` and `halted` are 0, all three report outputs are 0, and both slots are empty.
- R10: While a slot is occupied, a new `wr_post` (for the write slot) or `br_odd` (for the branch slot) is ignored, and the first fault's data is what gets reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_post | input | 1 | A posted operand write to an odd address was detected |
| wr_addr | input | AW | Address of that posted write |
| cur_pc | input | AW | Address of the instruction now in execution |
| insn_bound | input | 1 | The core reached an instruction boundary |
| opnd_start | input | 1 | The core is starting an operand access |
| br_odd | input | 1 | A branch with an odd target was decoded |
| br_target | input | AW | The odd branch target |
| br_not_taken | input | 1 | The decoded branch resolved as not taken |
| pc_load | input | 1 | The PC is being loaded with the branch target |
| exc_ctx | input | 2 | Current exception context: 0 normal, 1 bus error, 2 address error, 3 reset |
| fault_ack | input | 1 | The core has taken the reported fault |
| fault_req | output | 1 | One-cycle fault request |
| fault_addr | output | AW | Reported fault address |
| fault_ret_pc | output | AW | Reported return PC |
| fault_iptr | output | AW | Pointer to the instruction that caused the fault |
| halted | output | 1 | Sticky halt after a fault during critical exception handling |

## Verification
The hardest state to reach from the ports is the one where both slots are ready in the same cycle. To get there, the bench posts a write and decodes an odd branch in one cycle, then raises `insn_bound` and `pc_load` together in a later cycle, so that both faults become ready on the same edge. It acknowledges the first request late, which shows that the branch fault stays held. Escalation is reached by holding `exc_ctx` at a non-zero code across the cycle in which a fault becomes ready, once for each kind of fault. A behavioural model in the bench tracks every cycle of every scenario alongside the directed checks.

// File: rtl/afs_pkg.sv
package afs_pkg;

    typedef enum logic [1:0] {
        CTX_NORMAL  = 2'd0,
        CTX_BUSERR  = 2'd1,
        CTX_ADDRERR = 2'd2,
        CTX_RESET   = 2'd3
    } exc_ctx_e;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_PEND  = 2'd1,
        SLOT_READY = 2'd2
    } slot_st_e;

    function automatic logic ctx_is_critical(exc_ctx_e c);
        return c != CTX_NORMAL;
    endfunction

endpackage

// File: rtl/afs_slot.sv
module afs_slot
    import afs_pkg::*;
#(
    parameter int AW          = 32,
    parameter bit CANCELLABLE = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic [AW-1:0] arm_addr,
    input  logic [AW-1:0] arm_ret,
    input  logic [AW-1:0] arm_iptr,
    input  logic          fire,
    input  logic          cancel,
    input  logic          take,
    output logic          pend,
    output logic          ready,
    output logic [AW-1:0] rec_addr,
    output logic [AW-1:0] rec_ret,
    output logic [AW-1:0] rec_iptr
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] ret;
        logic [AW-1:0] iptr;
    } fault_rec_t;

    slot_st_e   st;
    fault_rec_t rec;
    logic       drop;

    generate
        if (CANCELLABLE) begin : g_cancel
            assign drop = cancel;
        end else begin : g_nocancel
            logic unused_cancel;
            assign unused_cancel = cancel;
            assign drop = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SLOT_IDLE;
            rec <= '0;
        end else begin
            case (st)
                SLOT_IDLE: begin
                    if (arm) begin
                        st  <= SLOT_PEND;
                        rec <= '{addr: arm_addr, ret: arm_ret, iptr: arm_iptr};
                    end
                end
                SLOT_PEND: begin
                    if (drop)      st <= SLOT_IDLE;
                    else if (fire) st <= SLOT_READY;
                end
                SLOT_READY: begin
                    if (take) st <= SLOT_IDLE;
                end
                default: st <= SLOT_IDLE;
            endcase
        end
    end

    assign pend     = (st == SLOT_PEND);
    assign ready    = (st == SLOT_READY);
    assign rec_addr = rec.addr;
    assign rec_ret  = rec.ret;
    assign rec_iptr = rec.iptr;

endmodule

// File: rtl/afs_issue.sv
module afs_issue
    import afs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  exc_ctx_e      ctx,
    input  logic          ack,
    input  logic          wr_rdy,
    input  logic [AW-1:0] wr_addr,
    input  logic [AW-1:0] wr_ret,
    input  logic [AW-1:0] wr_iptr,
    input  logic          br_rdy,
    input  logic [AW-1:0] br_addr,
    input  logic [AW-1:0] br_ret,
    input  logic [AW-1:0] br_iptr,
    output logic          wr_take,
    output logic          br_take,
    output logic          req,
    output logic [AW-1:0] rep_addr,
    output logic [AW-1:0] rep_ret,
    output logic [AW-1:0] rep_iptr,
    output logic          halted,
    output logic          busy
);

    logic          can_go;
    logic          issue;
    logic [AW-1:0] sel_addr;
    logic [AW-1:0] sel_ret;
    logic [AW-1:0] sel_iptr;

    always_comb begin
        can_go  = !busy && !halted;
        wr_take = can_go && wr_rdy;
        br_take = can_go && !wr_rdy && br_rdy;
        issue   = wr_take || br_take;
        if (wr_rdy) begin
            sel_addr = wr_addr;
            sel_ret  = wr_ret;
            sel_iptr = wr_iptr;
        end else begin
            sel_addr = br_addr;
            sel_ret  = br_ret;
            sel_iptr = br_iptr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req      <= 1'b0;
            busy     <= 1'b0;
            halted   <= 1'b0;
            rep_addr <= '0;
            rep_ret  <= '0;
            rep_iptr <= '0;
        end else begin
            req <= 1'b0;
            if (busy && ack) begin
                busy <= 1'b0;
            end else if (issue) begin
                if (ctx_is_critical(ctx)) begin
                    halted <= 1'b1;
                end else begin
                    req      <= 1'b1;
                    busy     <= 1'b1;
                    rep_addr <= sel_addr;
                    rep_ret  <= sel_ret;
                    rep_iptr <= sel_iptr;
                end
            end
        end
    end

endmodule

// File: rtl/addr_fault_seq.sv
module addr_fault_seq
    import afs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_post,
    input  logic [AW-1:0] wr_addr,
    input  logic [AW-1:0] cur_pc,
    input  logic          insn_bound,
    input  logic          opnd_start,
    input  logic          br_odd,
    input  logic [AW-1:0] br_target,
    input  logic          br_not_taken,
    input  logic          pc_load,
    input  logic [1:0]    exc_ctx,
    input  logic          fault_ack,
    output logic          fault_req,
    output logic [AW-1:0] fault_addr,
    output logic [AW-1:0] fault_ret_pc,
    output logic [AW-1:0] fault_iptr,
    output logic          halted
);

    logic          wr_pend, wr_rdy, wr_take;
    logic          br_pend, br_rdy, br_take;
    logic          busy;
    logic [AW-1:0] w_addr, w_ret, w_iptr;
    logic [AW-1:0] b_addr, b_ret, b_iptr;
    exc_ctx_e      ctx;

    assign ctx = exc_ctx_e'(exc_ctx);

    afs_slot #(.AW(AW), .CANCELLABLE(1'b0)) u_wr_slot (
        .clk      (clk),
        .rst      (rst),
        .arm      (wr_post),
        .arm_addr (wr_addr),
        .arm_ret  (cur_pc),
        .arm_iptr (cur_pc),
        .fire     (insn_bound | opnd_start),
        .cancel   (1'b0),
        .take     (wr_take),
        .pend     (wr_pend),
        .ready    (wr_rdy),
        .rec_addr (w_addr),
        .rec_ret  (w_ret),
        .rec_iptr (w_iptr)
    );

    afs_slot #(.AW(AW), .CANCELLABLE(1'b1)) u_br_slot (
        .clk      (clk),
        .rst      (rst),
        .arm      (br_odd),
        .arm_addr (br_target),
        .arm_ret  (br_target),
        .arm_iptr (cur_pc),
        .fire     (pc_load),
        .cancel   (br_not_taken),
        .take     (br_take),
        .pend     (br_pend),
        .ready    (br_rdy),
        .rec_addr (b_addr),
        .rec_ret  (b_ret),
        .rec_iptr (b_iptr)
    );

    afs_issue #(.AW(AW)) u_issue (
        .clk      (clk),
        .rst      (rst),
        .ctx      (ctx),
        .ack      (fault_ack),
        .wr_rdy   (wr_rdy),
        .wr_addr  (w_addr),
        .wr_ret   (w_ret),
        .wr_iptr  (w_iptr),
        .br_rdy   (br_rdy),
        .br_addr  (b_addr),
        .br_ret   (b_ret),
        .br_iptr  (b_iptr),
        .wr_take  (wr_take),
        .br_take  (br_take),
        .req      (fault_req),
        .rep_addr (fault_addr),
        .rep_ret  (fault_ret_pc),
        .rep_iptr (fault_iptr),
        .halted   (halted),
        .busy     (busy)
    );

endmodule

// File: rtl/afs_chk.sv
module afs_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          fault_req,
    input logic          fault_ack,
    input logic          halted,
    input logic [AW-1:0] fault_addr,
    input logic [AW-1:0] fault_ret_pc,
    input logic [AW-1:0] fault_iptr,
    input logic [1:0]    exc_ctx,
    input logic          busy,
    input logic          wr_pend,
    input logic          wr_rdy,
    input logic          insn_bound,
    input logic          opnd_start,
    input logic          br_pend,
    input logic          br_rdy,
    input logic          br_not_taken
);

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fault_req |=> !fault_req);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !fault_ack) |=> ($stable(fault_addr) && $stable(fault_ret_pc)
                                  && $stable(fault_iptr) && !fault_req));

    // R6
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    // R6
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halted |-> !fault_req);

    // R5
    ctx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_req) |-> ($past(exc_ctx) == 2'd0));

    // R1
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_pend && !insn_bound && !opnd_start) |=> wr_pend);

    // R4
    br_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (br_pend && br_not_taken) |=> (!br_rdy && !br_pend));

    // R7
    prio_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_rdy && br_rdy && !busy && !halted) |=> (br_rdy && !wr_rdy));

endmodule

bind addr_fault_seq afs_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fault_req    (fault_req),
    .fault_ack    (fault_ack),
    .halted       (halted),
    .fault_addr   (fault_addr),
    .fault_ret_pc (fault_ret_pc),
    .fault_iptr   (fault_iptr),
    .exc_ctx      (exc_ctx),
    .busy         (busy),
    .wr_pend      (wr_pend),
    .wr_rdy       (wr_rdy),
    .insn_bound   (insn_bound),
    .opnd_start   (opnd_start),
    .br_pend      (br_pend),
    .br_rdy       (br_rdy),
    .br_not_taken (br_not_taken)
);

// File: tb/addr_fault_seq_test.sv
`timescale 1ns/1ps
module addr_fault_seq_test;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_post = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [AW-1:0] cur_pc = '0;
    logic          insn_bound = 1'b0;
    logic          opnd_start = 1'b0;
    logic          br_odd = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic          br_not_taken = 1'b0;
    logic          pc_load = 1'b0;
    logic [1:0]    exc_ctx = 2'd0;
    logic          fault_ack = 1'b0;
    logic          fault_req;
    logic [AW-1:0] fault_addr;
    logic [AW-1:0] fault_ret_pc;
    logic [AW-1:0] fault_iptr;
    logic          halted;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    addr_fault_seq #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .wr_post(wr_post), .wr_addr(wr_addr), .cur_pc(cur_pc),
        .insn_bound(insn_bound), .opnd_start(opnd_start), .br_odd(br_odd),
        .br_target(br_target), .br_not_taken(br_not_taken), .pc_load(pc_load),
        .exc_ctx(exc_ctx), .fault_ack(fault_ack), .fault_req(fault_req),
        .fault_addr(fault_addr), .fault_ret_pc(fault_ret_pc), .fault_iptr(fault_iptr),
        .halted(halted)
    );

    // ---------------- behavioural reference model ----------------
    int          ws, bs;            // 0 empty, 1 waiting, 2 ready
    logic [31:0] wq_addr, wq_pc, bq_tgt, bq_pc;
    bit          m_busy, m_halt, m_req;
    logic [31:0] m_addr, m_ret, m_iptr;

    always @(posedge clk) begin
        bit take_w, take_b;
        take_w = 0; take_b = 0;
        if (rst) begin
            ws = 0; bs = 0; m_busy = 0; m_halt = 0; m_req = 0;
            m_addr = 0; m_ret = 0; m_iptr = 0;
            wq_addr = 0; wq_pc = 0; bq_tgt = 0; bq_pc = 0;
        end else begin
            m_req = 0;
            if (m_busy && fault_ack) m_busy = 0;
            else if (!m_busy && !m_halt && (ws == 2 || bs == 2)) begin
                if (ws == 2) take_w = 1; else take_b = 1;
                if (exc_ctx != 2'd0) m_halt = 1;
                else begin
                    m_req = 1; m_busy = 1;
                    m_addr = take_w ? wq_addr : bq_tgt;
                    m_ret  = take_w ? wq_pc   : bq_tgt;
                    m_iptr = take_w ? wq_pc   : bq_pc;
                end
            end
            if (ws == 0) begin
                if (wr_post) begin ws = 1; wq_addr = wr_addr; wq_pc = cur_pc; end
            end else if (ws == 1) begin
                if (insn_bound || opnd_start) ws = 2;
            end else if (take_w) ws = 0;
            if (bs == 0) begin
                if (br_odd) begin bs = 1; bq_tgt = br_target; bq_pc = cur_pc; end
            end else if (bs == 1) begin
                if (br_not_taken) bs = 0;
                else if (pc_load) bs = 2;
            end else if (take_b) bs = 0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (fault_req !== m_req || halted !== m_halt || fault_addr !== m_addr
                || fault_ret_pc !== m_ret || fault_iptr !== m_iptr) begin
                n_fail++;
                $display("FAIL MODEL(R8) req/halt/addr/ret/iptr actual %0b %0b %h %h %h expected %0b %0b %h %h %h",
                         fault_req, halted, fault_addr, fault_ret_pc, fault_iptr,
                         m_req, m_halt, m_addr, m_ret, m_iptr);
            end
        end
    end

    // ---------------- directed checks ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        wr_post = 0; insn_bound = 0; opnd_start = 0; br_odd = 0;
        br_not_taken = 0; pc_load = 0; fault_ack = 0;
    endtask

    task automatic nxt(input int n = 1);
        repeat (n) @(negedge clk);
        clear_in();
    endtask

    task automatic do_reset();
        rst = 1; clear_in(); exc_ctx = 0;
        nxt(2);
        rst = 0;
        nxt(1);
    endtask

    task automatic ack_it();
        fault_ack = 1; nxt(1);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R9 reset state
        chk("R9 fault_req", fault_req, 0);
        chk("R9 halted", halted, 0);
        chk("R9 fault_addr", fault_addr, 0);
        chk("R9 fault_iptr", fault_iptr, 0);

        // R1: post with boundary in same cycle, then a long wait
        wr_post = 1; wr_addr = 32'h1001; cur_pc = 32'h100; insn_bound = 1;
        nxt(1);
        nxt(4);
        chk("R1 held without trigger", fault_req, 0);
        insn_bound = 1; nxt(1);
        chk("R1 not yet one cycle after", fault_req, 0);
        nxt(1);
        chk("R1 request raised", fault_req, 1);
        chk("R1 fault_addr", fault_addr, 32'h1001);

        // R8: pulse, stable while unacked, no second request
        wr_post = 1; wr_addr = 32'h2001; cur_pc = 32'h200; nxt(1);
        // R10: second post while the slot is occupied is ignored
        wr_post = 1; wr_addr = 32'h3003; cur_pc = 32'h300; nxt(1);
        opnd_start = 1; nxt(1);
        nxt(3);
        chk("R8 single pulse", fault_req, 0);
        chk("R8 addr held", fault_addr, 32'h1001);
        ack_it();
        chk("R8 no issue in cycle after ack", fault_req, 0);
        nxt(1);
        chk("R8 waiting fault issued after ack", fault_req, 1);
        chk("R10 first write kept", fault_addr, 32'h2001);
        // R2: operand start released it, pc captured at post
        chk("R2 ret pc", fault_ret_pc, 32'h200);
        chk("R2 iptr", fault_iptr, 32'h200);
        ack_it();

        // R3: odd branch waits for pc load
        br_odd = 1; br_target = 32'h4005; cur_pc = 32'h400; nxt(1);
        cur_pc = 32'h404; nxt(3);
        chk("R3 held until pc load", fault_req, 0);
        pc_load = 1; nxt(1);
        nxt(1);
        chk("R3 request", fault_req, 1);
        chk("R3 fault_addr", fault_addr, 32'h4005);
        chk("R3 ret pc", fault_ret_pc, 32'h4005);
        chk("R3 iptr", fault_iptr, 32'h400);
        ack_it();

        // R4: not taken discards, later pc load does nothing
        br_odd = 1; br_target = 32'h5007; cur_pc = 32'h500; nxt(1);
        br_not_taken = 1; pc_load = 1; nxt(1);
        pc_load = 1; nxt(1);
        nxt(3);
        chk("R4 no request after discard", fault_req, 0);
        chk("R4 no halt", halted, 0);
        chk("R4 report unchanged", fault_addr, 32'h4005);

        // R7: both ready together, write first
        wr_post = 1; wr_addr = 32'h6001; br_odd = 1; br_target = 32'h7003; cur_pc = 32'h600;
        nxt(1);
        insn_bound = 1; pc_load = 1; nxt(1);
        nxt(1);
        chk("R7 write first", fault_addr, 32'h6001);
        chk("R7 request", fault_req, 1);
        nxt(3);
        chk("R7 branch held until ack", fault_req, 0);
        ack_it();
        nxt(1);
        chk("R7 branch second", fault_addr, 32'h7003);
        chk("R7 branch request", fault_req, 1);
        ack_it();

        // R5: bus-error context turns write fault into halt
        exc_ctx = 2'd1;
        wr_post = 1; wr_addr = 32'h8001; cur_pc = 32'h800; nxt(1);
        insn_bound = 1; nxt(1);
        nxt(1);
        chk("R5 halted", halted, 1);
        chk("R5 no request", fault_req, 0);

        // R6: sticky, no requests while halted
        exc_ctx = 2'd0;
        br_odd = 1; br_target = 32'h9009; cur_pc = 32'h900; nxt(1);
        pc_load = 1; nxt(1);
        nxt(4);
        chk("R6 halt sticky", halted, 1);
        chk("R6 no request while halted", fault_req, 0);
        do_reset();
        chk("R6 reset clears halt", halted, 0);

        // R5: reset-handling context with a branch fault
        exc_ctx = 2'd3;
        br_odd = 1; br_target = 32'hA00B; cur_pc = 32'hA00; nxt(1);
        pc_load = 1; nxt(1);
        nxt(1);
        chk("R5 branch halts", halted, 1);
        chk("R5 branch no request", fault_req, 0);
        exc_ctx = 2'd0;
        nxt(3);

        done = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule